// File: doc/BRIEF.md
# Write-Leveling Strobe-to-Clock Responder

This block is the memory-side responder used during write-leveling training. While training is switched on through a mode-register word, each byte lane watches its incoming data strobe. On every rising strobe edge it captures the level of the memory clock at that moment. It then reports the captured level on one designated data bit of that lane, called the prime bit, and drives every other enabled data bit low. The controller moves its strobe delay until the reported level flips, which tells it where the strobe lines up with the clock.

The strobe is oversampled by the block's own fast clock `clk`. The memory clock level arrives as the plain input `ck_in`. Leveling enable and output-buffer disable are decoded from fixed bit positions of the mode-register word. The device width selects how many data bits are driven and how many lanes respond. Strobe termination follows the ODT pin only while leveling is on, and data-bit termination is never requested. A case number summarises the combination of enable, buffer state and ODT. Every port is a plain level signal, so there is no valid/ready handshake and no back-pressure.

Top module: `wlr_top`

## Requirements
- R1: While leveling is on and outputs are enabled, a rising strobe edge in an active lane captures `ck_in`. A rising edge is a `clk` edge that samples the strobe at 1 after the previous `clk` edge sampled it at 0. The captured value appears on that lane's prime bit after that same `clk` edge.
- R2: The captured value is held until the next rising edge of the same strobe. A strobe that stays high, falls, or stays low leaves it unchanged, whatever `ck_in` does.
- R3: With `dev_width` 0 (4-bit) or 1 (8-bit), and also for code 3, which acts as 8-bit, only lane 0 responds and its prime bit is `dq_out[0]`. Output enables cover bits 3:0 for code 0 and bits 7:0 for codes 1 and 3. `dqs_rx_en[1]` is 0 and strobe 1 has no effect on `dq_out`.
- R4: With `dev_width` 2 (16-bit), `dq_out[0]` reports strobe 0 and `dq_out[8]` reports strobe 1, each lane independently of the other. All 16 output enables are set.
- R5: Bit 7 of `mr1_word` enables leveling. Bit 12 set to 1 disables the output buffers. All other bits of the word are ignored.
- R6: While leveling is on and bit 12 is 1, all `dq_oe` and `dqs_rx_en` bits are 0 and `dq_out` is 0. Strobe edges are ignored, so a value captured earlier reappears once the outputs are enabled again.
- R7: `dqs_term_on` equals leveling-on AND `odt_in`. `dq_term_on` is always 0.
- R8: While leveling is off, `dq_oe`, `dq_out`, `dqs_rx_en` and `dqs_term_on` are all 0, and every captured value is cleared. The prime bits therefore read 0 on the first cycle after leveling is entered.
- R9: `lvl_case` is 0 when leveling is off. It is 1 when outputs are off and ODT is 0, 2 when outputs are off and ODT is 1, 3 when outputs are on and ODT is 0, and 4 when outputs are on and ODT is 1.
- R10: After reset, every captured value is 0.
- R11: Every data bit other than a lane's prime bit (bit 0 of each 8-bit lane) is always driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ck_in | input | 1 | Memory clock level being sampled |
| dqs_in | input | 2 | Per-lane data strobe |
| odt_in | input | 1 | Termination-control pin |
| mr1_word | input | 16 | Mode-register word (bit 7 enable, bit 12 output-buffer disable) |
| dev_width | input | 2 | 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = as 8-bit |
| dq_out | output | 16 | Data-bit drive values |
| dq_oe | output | 16 | Data-bit output enables |
| dqs_rx_en | output | 2 | Per-lane strobe receiver active |
| dqs_term_on | output | 1 | Strobe termination on |
| dq_term_on | output | 1 | Data-bit termination on |
| lvl_case | output | 3 | Leveling case number 0 to 4 |

## Verification
Mode-driven outputs (`dq_oe`, `dqs_rx_en`, both termination flags, `lvl_case`) are combinational. They are due in the same cycle the mode inputs change. A capture passes through one strobe history register and one sample register, so it is visible on the prime bit after the first `clk` edge that sees the strobe high. Clearing on leveling exit also takes one edge. The bench changes inputs on falling edges and compares at the following falling edge, after exactly one rising edge has occurred. This matches both latencies with no ordering race.

// File: rtl/wlr_pkg.sv
package wlr_pkg;

  typedef enum logic [1:0] {
    WID_X4  = 2'd0,
    WID_X8  = 2'd1,
    WID_X16 = 2'd2,
    WID_RSV = 2'd3
  } dev_width_e;

  typedef enum logic [2:0] {
    CASE_OFF          = 3'd0,
    CASE_QOFF_NOTERM  = 3'd1,
    CASE_QOFF_TERM    = 3'd2,
    CASE_DRIVE_NOTERM = 3'd3,
    CASE_DRIVE_TERM   = 3'd4
  } lvl_case_e;

endpackage

// File: rtl/wlr_mode_decode.sv
module wlr_mode_decode
  import wlr_pkg::*;
#(
  parameter int MR_W     = 16,
  parameter int EN_BIT   = 7,
  parameter int QOFF_BIT = 12,
  parameter int LANES    = 2
) (
  input  logic [MR_W-1:0]  mr1_word,
  input  logic             odt_in,
  input  logic [1:0]       dev_width,
  output logic             lvl_on,
  output logic             drive_on,
  output logic [LANES-1:0] lane_active,
  output logic             dqs_term_on,
  output logic             dq_term_on,
  output logic [2:0]       lvl_case,
  output dev_width_e       width_sel
);

  logic unused_mr_bits;
  assign unused_mr_bits = ^mr1_word;

  assign width_sel   = dev_width_e'(dev_width);
  assign lvl_on      = mr1_word[EN_BIT];
  assign drive_on    = lvl_on && !mr1_word[QOFF_BIT];
  assign dqs_term_on = lvl_on && odt_in;
  assign dq_term_on  = 1'b0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_act
    if (l == 0) begin : g_base
      assign lane_active[l] = 1'b1;
    end else begin : g_wide
      assign lane_active[l] = (width_sel == WID_X16);
    end
  end

  lvl_case_e case_c;
  always_comb begin
    if (!lvl_on)                      case_c = CASE_OFF;
    else if (!drive_on && !odt_in)    case_c = CASE_QOFF_NOTERM;
    else if (!drive_on)               case_c = CASE_QOFF_TERM;
    else if (!odt_in)                 case_c = CASE_DRIVE_NOTERM;
    else                              case_c = CASE_DRIVE_TERM;
  end
  assign lvl_case = case_c;

endmodule

// File: rtl/wlr_lane_sampler.sv
module wlr_lane_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic ck_lvl,
  input  logic arm,
  input  logic clr,
  output logic sample
);

  logic strobe_q;
  logic strobe_rise;

  assign strobe_rise = strobe && !strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      sample   <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (clr)
        sample <= 1'b0;
      else if (arm && strobe_rise)
        sample <= ck_lvl;
    end
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && arm && strobe && !strobe_q) |=> (sample == $past(ck_lvl)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(strobe && !strobe_q)) |=> $stable(sample));

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !arm) |=> $stable(sample));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sample == 1'b0));

endmodule

// File: rtl/wlr_dq_drive.sv
module wlr_dq_drive
  import wlr_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int NARROW_W = 4,
  localparam int DQ_W    = LANES * LANE_W
) (
  input  logic [LANES-1:0] sample,
  input  logic [LANES-1:0] lane_active,
  input  logic             drive_on,
  input  dev_width_e       width_sel,
  output logic [DQ_W-1:0]  dq_out,
  output logic [DQ_W-1:0]  dq_oe
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_drive;
    assign lane_drive = drive_on && lane_active[l];
    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
      if (b == 0) begin : g_prime
        assign dq_out[l*LANE_W+b] = lane_drive && sample[l];
      end else begin : g_low
        assign dq_out[l*LANE_W+b] = 1'b0;
      end
      if (b < NARROW_W) begin : g_always
        assign dq_oe[l*LANE_W+b] = lane_drive;
      end else begin : g_wide
        assign dq_oe[l*LANE_W+b] = lane_drive && (width_sel != WID_X4);
      end
    end
  end

endmodule

// File: rtl/wlr_top.sv
module wlr_top
  import wlr_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int NARROW_W = 4,
  parameter int MR_W     = 16,
  parameter int EN_BIT   = 7,
  parameter int QOFF_BIT = 12,
  localparam int DQ_W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ck_in,
  input  logic [LANES-1:0] dqs_in,
  input  logic             odt_in,
  input  logic [MR_W-1:0]  mr1_word,
  input  logic [1:0]       dev_width,
  output logic [DQ_W-1:0]  dq_out,
  output logic [DQ_W-1:0]  dq_oe,
  output logic [LANES-1:0] dqs_rx_en,
  output logic             dqs_term_on,
  output logic             dq_term_on,
  output logic [2:0]       lvl_case
);

  logic             lvl_on;
  logic             drive_on;
  logic [LANES-1:0] lane_active;
  logic [LANES-1:0] sample;
  dev_width_e       width_sel;

  wlr_mode_decode #(
    .MR_W(MR_W), .EN_BIT(EN_BIT), .QOFF_BIT(QOFF_BIT), .LANES(LANES)
  ) u_mode (
    .mr1_word(mr1_word), .odt_in(odt_in), .dev_width(dev_width),
    .lvl_on(lvl_on), .drive_on(drive_on), .lane_active(lane_active),
    .dqs_term_on(dqs_term_on), .dq_term_on(dq_term_on),
    .lvl_case(lvl_case), .width_sel(width_sel)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_smp
    assign dqs_rx_en[l] = drive_on && lane_active[l];
    wlr_lane_sampler u_smp (
      .clk(clk), .rst_n(rst_n), .strobe(dqs_in[l]), .ck_lvl(ck_in),
      .arm(dqs_rx_en[l]), .clr(!lvl_on), .sample(sample[l])
    );
  end

  wlr_dq_drive #(
    .LANES(LANES), .LANE_W(LANE_W), .NARROW_W(NARROW_W)
  ) u_drive (
    .sample(sample), .lane_active(lane_active), .drive_on(drive_on),
    .width_sel(width_sel), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  localparam logic [LANE_W-1:0] LANE_PRIME = LANE_W'(1);
  localparam logic [DQ_W-1:0]   PRIME_MASK = {LANES{LANE_PRIME}};

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mr1_word[EN_BIT] |-> (dq_oe == '0 && dq_out == '0 && dqs_rx_en == '0 && !dqs_term_on));

  assert_qoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mr1_word[EN_BIT] && mr1_word[QOFF_BIT]) |-> (dq_oe == '0 && dqs_rx_en == '0));

  assert_nonprime_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out & ~PRIME_MASK) == '0);

  assert_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_term_on == (mr1_word[EN_BIT] && odt_in));

  assert_case_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_case <= 3'd4);

endmodule

// File: tb/tb_wlr_top.sv
module tb_wlr_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ck_in = 1'b0;
  logic [1:0]  dqs_in = 2'b00;
  logic        odt_in = 1'b0;
  logic [15:0] mr1_word = 16'h0000;
  logic [1:0]  dev_width = 2'd1;
  logic [15:0] dq_out, dq_oe;
  logic [1:0]  dqs_rx_en;
  logic        dqs_term_on, dq_term_on;
  logic [2:0]  lvl_case;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] EN   = 16'h0080;
  localparam logic [15:0] QOFF = 16'h1000;

  always #10 clk = ~clk;

  wlr_top dut (
    .clk(clk), .rst_n(rst_n), .ck_in(ck_in), .dqs_in(dqs_in), .odt_in(odt_in),
    .mr1_word(mr1_word), .dev_width(dev_width), .dq_out(dq_out), .dq_oe(dq_oe),
    .dqs_rx_en(dqs_rx_en), .dqs_term_on(dqs_term_on), .dq_term_on(dq_term_on),
    .lvl_case(lvl_case)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Pulse one strobe low then high with a given clock level.
  task automatic strobe_rise(input int lane, input logic lvl);
    dqs_in[lane] = 1'b0;
    step();
    ck_in = lvl;
    dqs_in[lane] = 1'b1;
    step();
  endtask

  task automatic t_reset();
    chk("R10 dq_out after reset", dq_out, 16'h0000);
    chk("R8 dq_oe when off", dq_oe, 16'h0000);
    chk("R9 case off", lvl_case, 3'd0);
    chk("R7 dq_term", dq_term_on, 1'b0);
  endtask

  task automatic t_x8();
    dev_width = 2'd1; mr1_word = EN; odt_in = 1'b0;
    step();
    chk("R8 prime reads 0 on entry", dq_out, 16'h0000);
    chk("R3 x8 enables", dq_oe, 16'h00FF);
    chk("R3 rx_en x8", dqs_rx_en, 2'b01);
    chk("R9 case 3", lvl_case, 3'd3);
    strobe_rise(0, 1'b1);
    chk("R1 capture high", dq_out, 16'h0001);
    ck_in = 1'b0; step();
    chk("R2 hold while strobe high", dq_out, 16'h0001);
    dqs_in[0] = 1'b0; step();
    chk("R2 hold on strobe fall", dq_out, 16'h0001);
    strobe_rise(1, 1'b0);
    chk("R3 strobe1 ignored in x8", dq_out, 16'h0001);
    strobe_rise(0, 1'b0);
    chk("R1 capture low", dq_out, 16'h0000);
    strobe_rise(1, 1'b1);
    chk("R3 strobe1 no effect", dq_out, 16'h0000);
    dqs_in = 2'b00;
  endtask

  task automatic t_x4();
    dev_width = 2'd0; step();
    chk("R3 x4 enables", dq_oe, 16'h000F);
    strobe_rise(0, 1'b1);
    chk("R1 x4 capture", dq_out, 16'h0001);
    dev_width = 2'd3; step();
    chk("R3 code 3 as x8", dq_oe, 16'h00FF);
    dqs_in = 2'b00;
  endtask

  task automatic t_x16();
    dev_width = 2'd2; step();
    chk("R4 x16 enables", dq_oe, 16'hFFFF);
    chk("R4 rx_en x16", dqs_rx_en, 2'b11);
    strobe_rise(1, 1'b1);
    chk("R4 upper lane independent", dq_out, 16'h0101);
    strobe_rise(0, 1'b0);
    chk("R4 lower lane independent", dq_out, 16'h0100);
    strobe_rise(0, 1'b1);
    chk("R11 only prime bits", dq_out, 16'h0101);
    dqs_in = 2'b00; step();
  endtask

  task automatic t_qoff();
    mr1_word = EN | QOFF; odt_in = 1'b0; step();
    chk("R6 oe off", dq_oe, 16'h0000);
    chk("R6 dq_out off", dq_out, 16'h0000);
    chk("R6 rx_en off", dqs_rx_en, 2'b00);
    chk("R9 case 1", lvl_case, 3'd1);
    odt_in = 1'b1; step();
    chk("R9 case 2", lvl_case, 3'd2);
    chk("R7 dqs term", dqs_term_on, 1'b1);
    strobe_rise(0, 1'b0);
    strobe_rise(1, 1'b0);
    dqs_in = 2'b00;
    mr1_word = EN; step();
    chk("R6 edges ignored while off", dq_out, 16'h0101);
    chk("R9 case 4", lvl_case, 3'd4);
    chk("R7 dq term stays off", dq_term_on, 1'b0);
  endtask

  task automatic t_disable();
    mr1_word = 16'hEF7F; odt_in = 1'b1; step();
    chk("R5 other bits ignored", lvl_case, 3'd0);
    chk("R8 dqs term off", dqs_term_on, 1'b0);
    chk("R8 oe off", dq_oe, 16'h0000);
    chk("R8 rx off", dqs_rx_en, 2'b00);
    mr1_word = 16'hEFFF; odt_in = 1'b0; step();
    chk("R5 bit7 on bit12 off", lvl_case, 3'd3);
    chk("R8 cleared on exit", dq_out, 16'h0000);
    strobe_rise(1, 1'b1);
    chk("R1 capture after re-entry", dq_out, 16'h0100);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_x8();
    t_x4();
    t_x16();
    t_qoff();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule